// File: doc/BRIEF.md
# Legacy Sound-Compatibility Port Register Block

This block sits behind a byte-wide I/O window and answers the legacy sound-compatibility offsets 0x6 and 0x8 through 0xF. It holds the command, data, status, latch and routing registers those offsets expose. It also applies the access side effects that make them behave like the old ports. Some reads change state: a latch read can flip the latch MSB, and a read of offset 0xE can raise an interrupt. Some writes raise interrupt flags, but only when the external timer-control byte enables them.

The host presents a 4-bit port offset together with read and/or write strobes and write data. Read data is combinational from the current state while the read strobe is high. Every state change, including the read side effects, takes place on the rising clock edge that ends the access. Interrupt requests leave the block as a one-cycle pulse and as a level. The interrupt status byte is also brought out as a summary. The timer-control and mixer-control bytes are inputs that belong to other blocks.

Top module: `compat_port_regs`

## Requirements
- R1: After reset every register is zero: the summary byte, the interrupt pulse and the interrupt level read 0, and reads of offsets 0x6 and 0xF return 0x00.
- R2: A write to 0x8 loads the command register, which reads back at 0xA. A write to 0xA loads the legacy status byte. A read of 0x8 returns the timer status byte when timerCtrl[0] is 1, and the legacy status byte when it is 0.
- R3: A read of 0xC returns the latch. When control register (written at 0xF) bit 5 is 1, the latch MSB is inverted at the end of the read; when it is 0, the latch is unchanged.
- R4: A read of 0xE returns the byte last written to 0xE. When control bit 7 is 1, the read also sets status bit 7 and raises an interrupt request.
- R5: A read of 0xF returns the status register ANDed with 0xF9, with bit 1 forced to 1 when mixerCtrl[3] is 1.
- R6: When timerCtrl[5] is 1, a write to 0x6 sets timer-status bit 3 and a write to 0xC sets timer-status bit 4. Either write also loads the interrupt status byte (read at 0x6 and output as irqStat) with 0x10 and raises a request. When timerCtrl[5] is 0, neither write touches those registers and no request is raised.
- R7: Writes to 0xC and to 0xD both store the data in the latch. A write to 0xD never raises a request.
- R8: When the command register holds 0x04 and timerCtrl[0] is 0, a write to 0x9 leaves the 0x9 data register alone and raises no request. With data bit 7 set, it ANDs timer status with 0x1F. With data bit 7 clear, it loads the timer data register, which reads at 0xB when control bits [2:0] are 2.
- R9: In every other case, a write to 0x9 loads the data register that reads at 0x9. If timerCtrl[1] is 1, it also sets timer-status bit 0, loads the interrupt status byte with 0x10 and raises a request.
- R10: A write to 0xB is steered by control bits [2:0]. Index 0 goes to the IRQ-select register when mixerCtrl[6] is 1 and to the DMA-select register when it is 0. Index 5 clears the status register. Index 6 goes to the jumper register. A read of 0xB returns the register the same index and mixer bit select (index 2 gives timer data), and 0xFF for other indices.
- R11: Every request makes irqPulse high for exactly the cycle after the access and sets irqLevel. irqLevel falls only on an index-5 write to 0xB while the interrupt status byte is zero.
- R12: When a read and a write reach the same offset in one cycle, both sets of side effects apply. The written value wins over a read-side latch flip, and requests from both sides merge into one pulse.
- R13: Reads of offsets 0x0–0x5, 0x7 and 0xD return 0xFF, and writes to offsets 0x0–0x5 and 0x7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| portOfs | input | 4 | Offset within the I/O window |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| timerCtrl | input | 8 | Timer-control byte from elsewhere |
| mixerCtrl | input | 8 | Mixer-control byte from elsewhere |
| rdData | output | 8 | Read data for portOfs, combinational |
| irqPulse | output | 1 | One-cycle interrupt request |
| irqLevel | output | 1 | Held interrupt request |
| irqStat | output | 8 | Interrupt status summary byte |

## Verification
The latch holds the collision that matters. A read of 0xC with control bit 5 set wants to flip the MSB in the same edge in which a write to 0xC loads new data. The bench raises both strobes in one cycle on offset 0xC with the flip enabled. It checks that the old latch appears on the read data and that the written byte, unflipped, comes back on the next read. The same double access on 0xE with control bit 7 set checks that a read-side request and a register write coexist and yield a single interrupt pulse.

// File: rtl/compat_port_pkg.sv
`timescale 1ns/1ps
package compat_port_pkg;
  localparam int DW = 8;
  localparam int OW = 4;

  // plain load-only registers, indices into the register array
  localparam int IX_CMD   = 0;
  localparam int IX_LSTAT = 1;
  localparam int IX_DATA  = 2;
  localparam int IX_TDATA = 3;
  localparam int IX_EREG  = 4;
  localparam int IX_CTRL  = 5;
  localparam int IX_IRQS  = 6;
  localparam int IX_DMAS  = 7;
  localparam int IX_JUMP  = 8;
  localparam int NREG     = 9;

  localparam logic [OW-1:0] OFS_IRQST  = 4'h6;
  localparam logic [OW-1:0] OFS_STAT   = 4'h8;
  localparam logic [OW-1:0] OFS_DATA   = 4'h9;
  localparam logic [OW-1:0] OFS_CMD    = 4'hA;
  localparam logic [OW-1:0] OFS_ROUTE  = 4'hB;
  localparam logic [OW-1:0] OFS_LATCH  = 4'hC;
  localparam logic [OW-1:0] OFS_LATCHQ = 4'hD;
  localparam logic [OW-1:0] OFS_EREG   = 4'hE;
  localparam logic [OW-1:0] OFS_CTRL   = 4'hF;

  localparam logic [DW-1:0] TIMER_CMD   = 8'h04;
  localparam logic [DW-1:0] IRQ_LOAD    = 8'h10;
  localparam logic [DW-1:0] NO_REG      = 8'hFF;
  localparam logic [DW-1:0] STAT_RDMASK = 8'hF9;
  localparam logic [DW-1:0] TSTAT_KEEP  = 8'h1F;

  localparam logic [2:0] RT_SELECT = 3'd0;
  localparam logic [2:0] RT_TDATA  = 3'd2;
  localparam logic [2:0] RT_CLEAR  = 3'd5;
  localparam logic [2:0] RT_JUMP   = 3'd6;

  typedef struct packed {
    logic [NREG-1:0] load;
    logic maskTs;
    logic setTs0;
    logic setTs3;
    logic setTs4;
    logic loadIrqSt;
    logic wrLatch;
    logic flipLatch;
    logic setStat7;
    logic clrStat;
    logic irqReq;
  } strobe_t;
endpackage

// File: rtl/compat_port_byte.sv
`timescale 1ns/1ps
module compat_port_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/compat_port_ctrl.sv
`timescale 1ns/1ps
module compat_port_ctrl
  import compat_port_pkg::*;
(
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic [OW-1:0] portOfs,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] timerCtrl,
  input  logic          mixIrqSel,
  input  logic [DW-1:0] cmdQ,
  input  logic [DW-1:0] ctrlQ,
  output strobe_t       stb
);
  logic timerMode;
  logic unusedBits;

  assign timerMode  = (cmdQ == TIMER_CMD) && !timerCtrl[0];
  assign unusedBits = ^{timerCtrl[7:6], timerCtrl[4:2], ctrlQ[6], ctrlQ[4:3], wrData[6:0]};

  always_comb begin
    stb = '0;
    if (wrStb) begin
      case (portOfs)
        OFS_IRQST: begin
          if (timerCtrl[5]) begin
            stb.setTs3    = 1'b1;
            stb.loadIrqSt = 1'b1;
            stb.irqReq    = 1'b1;
          end
        end
        OFS_STAT: stb.load[IX_CMD]   = 1'b1;
        OFS_CMD:  stb.load[IX_LSTAT] = 1'b1;
        OFS_DATA: begin
          if (timerMode) begin
            if (wrData[7]) stb.maskTs          = 1'b1;
            else           stb.load[IX_TDATA]  = 1'b1;
          end else begin
            stb.load[IX_DATA] = 1'b1;
            if (timerCtrl[1]) begin
              stb.setTs0    = 1'b1;
              stb.loadIrqSt = 1'b1;
              stb.irqReq    = 1'b1;
            end
          end
        end
        OFS_ROUTE: begin
          case (ctrlQ[2:0])
            RT_SELECT: begin
              if (mixIrqSel) stb.load[IX_IRQS] = 1'b1;
              else           stb.load[IX_DMAS] = 1'b1;
            end
            RT_CLEAR: stb.clrStat         = 1'b1;
            RT_JUMP:  stb.load[IX_JUMP]   = 1'b1;
            default:  ;
          endcase
        end
        OFS_LATCH: begin
          stb.wrLatch = 1'b1;
          if (timerCtrl[5]) begin
            stb.setTs4    = 1'b1;
            stb.loadIrqSt = 1'b1;
            stb.irqReq    = 1'b1;
          end
        end
        OFS_LATCHQ: stb.wrLatch        = 1'b1;
        OFS_EREG:   stb.load[IX_EREG]  = 1'b1;
        OFS_CTRL:   stb.load[IX_CTRL]  = 1'b1;
        default: ;
      endcase
    end
    if (rdStb) begin
      if (portOfs == OFS_LATCH && ctrlQ[5]) stb.flipLatch = 1'b1;
      if (portOfs == OFS_EREG && ctrlQ[7]) begin
        stb.setStat7 = 1'b1;
        stb.irqReq   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/compat_port_dp.sv
`timescale 1ns/1ps
module compat_port_dp
  import compat_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic [OW-1:0] portOfs,
  input  logic [DW-1:0] wrData,
  input  logic          timerView,
  input  logic          mixIrqSel,
  input  logic          mixDmaFlag,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] cmdQ,
  output logic [DW-1:0] ctrlQ,
  output logic [DW-1:0] latchQ,
  output logic [DW-1:0] statQ,
  output logic [DW-1:0] irqStat,
  output logic          irqPulse,
  output logic          irqLevel
);
  logic [DW-1:0] regQ [NREG];
  logic [DW-1:0] timerStatQ;
  logic [DW-1:0] routeRd;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    compat_port_byte #(.W(DW)) u_byte (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (stb.load[g]),
      .d    (wrData),
      .q    (regQ[g])
    );
  end

  assign cmdQ  = regQ[IX_CMD];
  assign ctrlQ = regQ[IX_CTRL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latchQ     <= '0;
      statQ      <= '0;
      timerStatQ <= '0;
      irqStat    <= '0;
      irqPulse   <= 1'b0;
      irqLevel   <= 1'b0;
    end else begin
      if (stb.wrLatch)        latchQ    <= wrData;
      else if (stb.flipLatch) latchQ[7] <= ~latchQ[7];

      if (stb.clrStat)       statQ    <= '0;
      else if (stb.setStat7) statQ[7] <= 1'b1;

      timerStatQ <= (stb.maskTs ? (timerStatQ & TSTAT_KEEP) : timerStatQ)
                  | {3'b000, stb.setTs4, stb.setTs3, 2'b00, stb.setTs0};

      if (stb.loadIrqSt) irqStat <= IRQ_LOAD;

      irqPulse <= stb.irqReq;
      if (stb.irqReq)                            irqLevel <= 1'b1;
      else if (stb.clrStat && irqStat == '0)     irqLevel <= 1'b0;
    end
  end

  always_comb begin
    case (ctrlQ[2:0])
      RT_SELECT: routeRd = mixIrqSel ? regQ[IX_IRQS] : regQ[IX_DMAS];
      RT_TDATA:  routeRd = regQ[IX_TDATA];
      RT_JUMP:   routeRd = regQ[IX_JUMP];
      default:   routeRd = NO_REG;
    endcase
  end

  always_comb begin
    case (portOfs)
      OFS_IRQST: rdData = irqStat;
      OFS_STAT:  rdData = timerView ? timerStatQ : regQ[IX_LSTAT];
      OFS_DATA:  rdData = regQ[IX_DATA];
      OFS_CMD:   rdData = regQ[IX_CMD];
      OFS_ROUTE: rdData = routeRd;
      OFS_LATCH: rdData = latchQ;
      OFS_EREG:  rdData = regQ[IX_EREG];
      OFS_CTRL:  rdData = (statQ & STAT_RDMASK) | {6'b0, mixDmaFlag, 1'b0};
      default:   rdData = NO_REG;
    endcase
  end
endmodule

// File: rtl/compat_port_regs.sv
`timescale 1ns/1ps
module compat_port_regs
  import compat_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] portOfs,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] timerCtrl,
  input  logic [DW-1:0] mixerCtrl,
  output logic [DW-1:0] rdData,
  output logic          irqPulse,
  output logic          irqLevel,
  output logic [DW-1:0] irqStat
);
  strobe_t       stb;
  logic [DW-1:0] cmdQ;
  logic [DW-1:0] ctrlQ;
  logic [DW-1:0] latchQ;
  logic [DW-1:0] statQ;
  logic          unusedMix;

  assign unusedMix = ^{mixerCtrl[7], mixerCtrl[5:4], mixerCtrl[2:0]};

  compat_port_ctrl u_ctrl (
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .portOfs  (portOfs),
    .wrData   (wrData),
    .timerCtrl(timerCtrl),
    .mixIrqSel(mixerCtrl[6]),
    .cmdQ     (cmdQ),
    .ctrlQ    (ctrlQ),
    .stb      (stb)
  );

  compat_port_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .portOfs   (portOfs),
    .wrData    (wrData),
    .timerView (timerCtrl[0]),
    .mixIrqSel (mixerCtrl[6]),
    .mixDmaFlag(mixerCtrl[3]),
    .rdData    (rdData),
    .cmdQ      (cmdQ),
    .ctrlQ     (ctrlQ),
    .latchQ    (latchQ),
    .statQ     (statQ),
    .irqStat   (irqStat),
    .irqPulse  (irqPulse),
    .irqLevel  (irqLevel)
  );
endmodule

// File: rtl/compat_port_regs_chk.sv
`timescale 1ns/1ps
module compat_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] portOfs,
  input logic       rdStb,
  input logic       wrStb,
  input logic [7:0] wrData,
  input logic       sbEnable,
  input logic       rdFlipEn,
  input logic       rdIrqEn,
  input logic [7:0] latchQ,
  input logic       stat7,
  input logic [7:0] rdData,
  input logic       irqPulse,
  input logic       irqLevel,
  input logic [7:0] irqStat
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_pulse_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> irqLevel);

  p_sb_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(wrStb && portOfs == 4'h6 && sbEnable)) |-> (irqStat == 8'h10 && irqPulse));

  p_e_read_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rdStb && portOfs == 4'hE && rdIrqEn)) |-> (stat7 && irqPulse));

  p_latch_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rdStb && !wrStb && portOfs == 4'hC && rdFlipEn))
      |-> (latchQ == {~$past(latchQ[7]), $past(latchQ[6:0])}));

  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(wrStb && (portOfs == 4'hC || portOfs == 4'hD))) |-> (latchQ == $past(wrData)));

  p_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (portOfs < 4'h6 || portOfs == 4'h7 || portOfs == 4'hD) |-> (rdData == 8'hFF));
endmodule

bind compat_port_regs compat_port_regs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .portOfs (portOfs),
  .rdStb   (rdStb),
  .wrStb   (wrStb),
  .wrData  (wrData),
  .sbEnable(timerCtrl[5]),
  .rdFlipEn(ctrlQ[5]),
  .rdIrqEn (ctrlQ[7]),
  .latchQ  (latchQ),
  .stat7   (statQ[7]),
  .rdData  (rdData),
  .irqPulse(irqPulse),
  .irqLevel(irqLevel),
  .irqStat (irqStat)
);

// File: tb/compat_port_regs_test.sv
`timescale 1ns/1ps
module compat_port_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] portOfs = '0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] timerCtrl = '0;
  logic [7:0] mixerCtrl = '0;
  logic [7:0] rdData;
  logic       irqPulse;
  logic       irqLevel;
  logic [7:0] irqStat;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  compat_port_regs uut (
    .clk(clk), .rst_n(rst_n), .portOfs(portOfs), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .timerCtrl(timerCtrl), .mixerCtrl(mixerCtrl),
    .rdData(rdData), .irqPulse(irqPulse), .irqLevel(irqLevel), .irqStat(irqStat)
  );

  typedef struct packed {
    logic       isRd;
    logic [3:0] ofs;
    logic [7:0] val;
    logic [7:0] tctl;
    logic [7:0] mix;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'h8, 8'h5A, 8'h00, 8'h00, 4'd2},   // R2 command load
    '{1'b1, 4'hA, 8'h5A, 8'h00, 8'h00, 4'd2},   // R2 command readback
    '{1'b0, 4'hA, 8'h33, 8'h00, 8'h00, 4'd2},   // R2 legacy status load
    '{1'b1, 4'h8, 8'h33, 8'h00, 8'h00, 4'd2},   // R2 legacy view
    '{1'b1, 4'h8, 8'h00, 8'h01, 8'h00, 4'd2},   // R2 timer view
    '{1'b0, 4'hD, 8'h81, 8'h00, 8'h00, 4'd7},   // R7 latch via 0xD
    '{1'b1, 4'hC, 8'h81, 8'h00, 8'h00, 4'd7},   // R7 latch readback
    '{1'b1, 4'hC, 8'h81, 8'h00, 8'h00, 4'd3},   // R3 no flip, control bit 5 clear
    '{1'b0, 4'hE, 8'h44, 8'h00, 8'h00, 4'd4},   // R4 store 0xE
    '{1'b1, 4'hE, 8'h44, 8'h00, 8'h00, 4'd4},   // R4 readback
    '{1'b0, 4'h9, 8'h66, 8'h00, 8'h00, 4'd9},   // R9 plain data
    '{1'b1, 4'h9, 8'h66, 8'h00, 8'h00, 4'd9},   // R9 readback
    '{1'b0, 4'hB, 8'h21, 8'h00, 8'h00, 4'd10},  // R10 DMA select
    '{1'b1, 4'hB, 8'h21, 8'h00, 8'h00, 4'd10},  // R10
    '{1'b1, 4'hB, 8'h00, 8'h00, 8'h40, 4'd10},  // R10 IRQ select still zero
    '{1'b0, 4'hB, 8'h5C, 8'h00, 8'h40, 4'd10},  // R10 IRQ select
    '{1'b1, 4'hB, 8'h5C, 8'h00, 8'h40, 4'd10},  // R10
    '{1'b1, 4'hB, 8'h21, 8'h00, 8'h00, 4'd10},  // R10 DMA select kept
    '{1'b1, 4'h3, 8'hFF, 8'h00, 8'h00, 4'd13},  // R13
    '{1'b1, 4'h7, 8'hFF, 8'h00, 8'h00, 4'd13},  // R13
    '{1'b0, 4'h3, 8'hAA, 8'h00, 8'h00, 4'd13},  // R13 ignored write
    '{1'b1, 4'h0, 8'hFF, 8'h00, 8'h00, 4'd13}   // R13
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [3:0] ofs,
                        input logic [7:0] d, input logic [7:0] tc, input logic [7:0] mx,
                        output logic [7:0] got);
    @(negedge clk);
    portOfs = ofs; rdStb = rd; wrStb = wr; wrData = d; timerCtrl = tc; mixerCtrl = mx;
    #1 got = rdData;
    @(posedge clk);
    #1 rdStb = 1'b0; wrStb = 1'b0;
  endtask

  logic [7:0] got;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=00 expected=01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1", irqStat, 8'h00, "summary after reset");
    check("R1", {7'b0, irqLevel}, 8'h00, "level after reset");
    check("R1", {7'b0, irqPulse}, 8'h00, "pulse after reset");
    access(1, 0, 4'h6, 8'h00, 8'h00, 8'h00, got); check("R1", got, 8'h00, "0x6 after reset");
    access(1, 0, 4'hF, 8'h00, 8'h00, 8'h00, got); check("R1", got, 8'h00, "0xF after reset");

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].isRd, !VECS[i].isRd, VECS[i].ofs, VECS[i].val,
             VECS[i].tctl, VECS[i].mix, got);
      if (VECS[i].isRd) check($sformatf("R%0d", VECS[i].req), got, VECS[i].val,
                              $sformatf("vector %0d", i));
      check($sformatf("R%0d", VECS[i].req), {7'b0, irqPulse}, 8'h00,
            $sformatf("no request vector %0d", i));
    end

    // R3 latch flip on read
    access(0, 1, 4'hF, 8'h20, 8'h00, 8'h00, got);
    access(1, 0, 4'hC, 8'h00, 8'h00, 8'h00, got); check("R3", got, 8'h81, "first read");
    access(1, 0, 4'hC, 8'h00, 8'h00, 8'h00, got); check("R3", got, 8'h01, "flipped");
    access(1, 0, 4'hC, 8'h00, 8'h00, 8'h00, got); check("R3", got, 8'h81, "flipped back");

    // R12 read and write of latch in one cycle
    access(1, 1, 4'hC, 8'h42, 8'h00, 8'h00, got); check("R12", got, 8'h01, "old latch seen");
    check("R12", {7'b0, irqPulse}, 8'h00, "no request");
    access(1, 0, 4'hC, 8'h00, 8'h00, 8'h00, got); check("R12", got, 8'h42, "write wins");

    // R4 / R5 read of 0xE raising a request
    access(0, 1, 4'hF, 8'h80, 8'h00, 8'h00, got);
    access(1, 0, 4'hE, 8'h00, 8'h00, 8'h00, got); check("R4", got, 8'h44, "0xE data");
    check("R4", {7'b0, irqPulse}, 8'h01, "pulse on read");
    check("R11", {7'b0, irqLevel}, 8'h01, "level set");
    access(1, 0, 4'hF, 8'h00, 8'h00, 8'h00, got); check("R5", got, 8'h80, "status bit 7");
    check("R11", {7'b0, irqPulse}, 8'h00, "pulse one cycle");
    access(1, 0, 4'hF, 8'h00, 8'h00, 8'h08, got); check("R5", got, 8'h82, "mixer flag");

    // R11 / R10 index-5 clear with zero summary
    access(0, 1, 4'hF, 8'h85, 8'h00, 8'h00, got);
    access(0, 1, 4'hB, 8'h00, 8'h00, 8'h00, got);
    check("R11", {7'b0, irqLevel}, 8'h00, "level cleared");
    access(1, 0, 4'hF, 8'h00, 8'h00, 8'h00, got); check("R10", got, 8'h00, "status cleared");

    // R6 compatibility-interrupt writes
    access(0, 1, 4'h6, 8'h00, 8'h00, 8'h00, got);
    check("R6", {7'b0, irqPulse}, 8'h00, "disabled no pulse");
    check("R6", irqStat, 8'h00, "disabled no load");
    access(0, 1, 4'h6, 8'h00, 8'h20, 8'h00, got);
    check("R6", {7'b0, irqPulse}, 8'h01, "0x6 pulse");
    check("R6", irqStat, 8'h10, "summary loaded");
    access(1, 0, 4'h8, 8'h00, 8'h21, 8'h00, got); check("R6", got, 8'h08, "timer bit 3");
    access(0, 1, 4'hC, 8'h10, 8'h20, 8'h00, got);
    check("R6", {7'b0, irqPulse}, 8'h01, "0xC pulse");
    access(1, 0, 4'h8, 8'h00, 8'h01, 8'h00, got); check("R6", got, 8'h18, "timer bit 4");
    access(1, 0, 4'hC, 8'h00, 8'h00, 8'h00, got); check("R7", got, 8'h10, "latch from 0xC");
    access(0, 1, 4'hD, 8'h23, 8'h20, 8'h00, got);
    check("R7", {7'b0, irqPulse}, 8'h00, "0xD no request");
    access(1, 0, 4'h6, 8'h00, 8'h00, 8'h00, got); check("R6", got, 8'h10, "0x6 read");

    // R11 index-5 clear with nonzero summary keeps level
    access(0, 1, 4'hB, 8'h00, 8'h00, 8'h00, got);
    check("R11", {7'b0, irqLevel}, 8'h01, "level kept");

    // R8 timer command mode
    access(0, 1, 4'h8, 8'h04, 8'h00, 8'h00, got);
    access(0, 1, 4'h9, 8'h80, 8'h02, 8'h00, got);
    check("R8", {7'b0, irqPulse}, 8'h00, "no pulse mask write");
    access(0, 1, 4'h9, 8'h12, 8'h02, 8'h00, got);
    check("R8", {7'b0, irqPulse}, 8'h00, "no pulse timer data");
    access(1, 0, 4'h9, 8'h00, 8'h00, 8'h00, got); check("R8", got, 8'h66, "data untouched");
    access(1, 0, 4'h8, 8'h00, 8'h01, 8'h00, got); check("R8", got, 8'h18, "timer status kept");
    access(0, 1, 4'hF, 8'h02, 8'h00, 8'h00, got);
    access(1, 0, 4'hB, 8'h00, 8'h00, 8'h00, got); check("R8", got, 8'h12, "timer data");

    // R9 normal data path with request
    access(0, 1, 4'h9, 8'h77, 8'h03, 8'h00, got);
    check("R9", {7'b0, irqPulse}, 8'h01, "data pulse");
    access(1, 0, 4'h9, 8'h00, 8'h00, 8'h00, got); check("R9", got, 8'h77, "data stored");
    access(1, 0, 4'h8, 8'h00, 8'h01, 8'h00, got); check("R9", got, 8'h19, "timer bit 0");

    // R12 read and write of 0xE in one cycle, single pulse
    access(0, 1, 4'hF, 8'h80, 8'h00, 8'h00, got);
    access(1, 1, 4'hE, 8'h55, 8'h00, 8'h00, got); check("R12", got, 8'h44, "old 0xE seen");
    check("R12", {7'b0, irqPulse}, 8'h01, "merged pulse");
    access(1, 0, 4'hE, 8'h00, 8'h00, 8'h00, got); check("R12", got, 8'h55, "0xE written");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule